// File: doc/BRIEF.md
# Video Address and Line-Interrupt Generator

This block produces the video-memory address for a bitmapped display and a per-line interrupt that lets the CPU run horizontal timing in software. An 8-bit pixel-pair counter advances on a step strobe. A phase input that toggles twice per step supplies the lowest address bit, so two words are fetched for each counter value. The top nine address bits come from a line-base register that software reloads with the start of the next line's data.

The interrupt is decoded from two fixed counter values. It rises after the counter reaches 160 and falls after it reaches 192. The falling edge gives software an exact reference point to lock onto. The block never ends a line by itself. The CPU ends each line with a synchronous counter clear, normally when the counter reads 199.

When the CPU requests access, the low nine address bits come from a CPU-supplied value and the memory-to-pixel output enable drops. The counter keeps running during CPU access. The access mode is registered, so it follows the request one clock later.

Top module: `vid_addr_gen`

## Requirements
- R1: After the asynchronous active-low reset, the counter and line base are zero, `irq` is 0, the block is in video mode (`vid_oe` = 1), and `vaddr` equals `half_sel`.
- R2: On each clock with `step_en` = 1 and `cnt_clr` = 0, the counter increments by one and wraps from 255 to 0. With `step_en` = 0 it holds its value.
- R3: `cnt_clr` = 1 sets the counter to 0 on the next clock and takes priority over `step_en`.
- R4: In video mode, `vaddr[8:1]` equals the counter and `vaddr[0]` equals `half_sel`.
- R5: `line_ld` = 1 loads `line_din` into `vaddr[17:9]` on the next clock. Otherwise the line base holds.
- R6: `irq` goes to 1 on the clock after the one where the counter takes the value 160.
- R7: `irq` goes to 0 on the clock after the one where the counter takes the value 192. It changes at no other counter value, and a counter clear does not change it.
- R8: One clock after `cpu_req` is sampled at 1, `vaddr[8:0]` equals `cpu_addr` and `vid_oe` is 0. One clock after it is sampled at 0, video mode resumes with `vid_oe` = 1.
- R9: The counter keeps stepping while CPU mode is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| step_en | input | 1 | Counter advance strobe (one per pixel pair) |
| half_sel | input | 1 | Fetch phase; becomes address bit 0 in video mode |
| cnt_clr | input | 1 | Synchronous counter clear from the CPU |
| cpu_req | input | 1 | CPU access request, sampled every clock |
| cpu_addr | input | 9 | Low address bits used in CPU mode |
| line_ld | input | 1 | Load strobe for the line base |
| line_din | input | 9 | New line base value |
| vaddr | output | 18 | Video memory address |
| irq | output | 1 | Registered line interrupt level |
| vid_oe | output | 1 | Memory-to-pixel output enable, low in CPU mode |

## Verification
The assertions assume the strobes and data inputs are stable and known at every rising edge. They also assume that `cnt_clr` and `step_en` are the only sources of counter change, so every count transition can be traced to one of them. The bench changes all inputs only on the falling edge and holds every input at a defined level from time zero. It steps the counter one clock at a time through both window boundaries and through a full wrap, so the interrupt edges land on known cycles.

// File: rtl/vid_addr_gen.sv
module vid_addr_gen #(
  parameter int CNT_W   = 8,
  parameter int BASE_W  = 9,
  parameter int IRQ_ON  = 160,
  parameter int IRQ_OFF = 192
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    step_en,
  input  logic                    half_sel,
  input  logic                    cnt_clr,
  input  logic                    cpu_req,
  input  logic [CNT_W:0]          cpu_addr,
  input  logic                    line_ld,
  input  logic [BASE_W-1:0]       line_din,
  output logic [BASE_W+CNT_W:0]   vaddr,
  output logic                    irq,
  output logic                    vid_oe
);
  localparam logic [CNT_W-1:0] ON_V  = CNT_W'(IRQ_ON);
  localparam logic [CNT_W-1:0] OFF_V = CNT_W'(IRQ_OFF);

  logic [CNT_W-1:0]  cnt;
  logic [BASE_W-1:0] base;
  logic              cpu_mode;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)          cnt <= '0;
    else if (cnt_clr)    cnt <= '0;
    else if (step_en)    cnt <= cnt + 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)          base <= '0;
    else if (line_ld)    base <= line_din;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)          cpu_mode <= 1'b0;
    else                 cpu_mode <= cpu_req;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)             irq <= 1'b0;
    else if (cnt == ON_V)   irq <= 1'b1;
    else if (cnt == OFF_V)  irq <= 1'b0;

  assign vid_oe = !cpu_mode;
  assign vaddr  = {base, cpu_mode ? cpu_addr : {cnt, half_sel}};

  assert_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en && !cnt_clr) |=> cnt == $past(cnt) + 1'b1);
  assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!step_en && !cnt_clr) |=> $stable(cnt));
  assert_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_clr |=> cnt == '0);
  assert_base_R5: assert property (@(posedge clk) disable iff (!rst_n)
    line_ld |=> vaddr[BASE_W+CNT_W:CNT_W+1] == $past(line_din));
  assert_irq_rise_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(cnt) == ON_V);
  assert_irq_fall_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq) |-> $past(cnt) == OFF_V);
  assert_cpu_mode_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_req |=> (!vid_oe && vaddr[CNT_W:0] == cpu_addr));
  assert_vid_mode_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !cpu_req |=> (vid_oe && vaddr[0] == half_sel));
endmodule

// File: tb/vid_addr_gen_tb.sv
module vid_addr_gen_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        step_en = 1'b0, half_sel = 1'b0, cnt_clr = 1'b0, cpu_req = 1'b0, line_ld = 1'b0;
  logic [8:0]  cpu_addr = '0, line_din = '0;
  logic [17:0] vaddr;
  logic        irq, vid_oe;
  int          n_run = 0, n_fail = 0;
  logic [7:0]  m_cnt = '0;
  logic [8:0]  m_base = '0;

  always #10 clk = ~clk;

  vid_addr_gen u_dut (.clk(clk), .rst_n(rst_n), .step_en(step_en), .half_sel(half_sel),
    .cnt_clr(cnt_clr), .cpu_req(cpu_req), .cpu_addr(cpu_addr), .line_ld(line_ld),
    .line_din(line_din), .vaddr(vaddr), .irq(irq), .vid_oe(vid_oe));

  typedef struct packed {
    logic       step, clr, half, req;
    logic [8:0] caddr;
    logic       ld;
    logic [8:0] din;
    logic [17:0] eaddr;
    logic       eoe;
  } vec_t;

  localparam vec_t VEC [8] = '{
    '{1'b1,1'b0,1'b0,1'b0,9'h000,1'b0,9'h000,18'h00002,1'b1},
    '{1'b1,1'b0,1'b1,1'b0,9'h000,1'b0,9'h000,18'h00005,1'b1},
    '{1'b0,1'b0,1'b0,1'b0,9'h000,1'b1,9'h1A5,18'h34A04,1'b1},
    '{1'b1,1'b1,1'b1,1'b0,9'h000,1'b0,9'h000,18'h34A01,1'b1},
    '{1'b1,1'b0,1'b0,1'b1,9'h0F3,1'b0,9'h000,18'h34AF3,1'b0},
    '{1'b1,1'b0,1'b0,1'b1,9'h100,1'b0,9'h000,18'h34B00,1'b0},
    '{1'b0,1'b0,1'b0,1'b0,9'h000,1'b0,9'h000,18'h34A04,1'b1},
    '{1'b0,1'b0,1'b0,1'b0,9'h000,1'b1,9'h000,18'h00004,1'b1}
  };

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic steps(int n);
    for (int i = 0; i < n; i++) begin
      step_en = 1'b1;
      cyc();
      m_cnt = m_cnt + 8'd1;
    end
    step_en = 1'b0;
  endtask

  initial begin
    #2000000;
    n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #35;
    chk("R1 addr", vaddr, 0);
    chk("R1 irq", irq, 0);
    chk("R1 oe", vid_oe, 1);
    @(negedge clk);
    rst_n = 1'b1;
    half_sel = 1'b1;
    #1 chk("R1 addr phase", vaddr, 1);
    @(negedge clk);
    half_sel = 1'b0;
    for (int k = 0; k < 8; k++) begin
      step_en = VEC[k].step; cnt_clr = VEC[k].clr; half_sel = VEC[k].half;
      cpu_req = VEC[k].req; cpu_addr = VEC[k].caddr; line_ld = VEC[k].ld; line_din = VEC[k].din;
      cyc();
      chk("R2 R3 R4 R5 R8 R9 vector addr", vaddr, VEC[k].eaddr);
      chk("R8 vector oe", vid_oe, VEC[k].eoe);
    end
    step_en = 0; cnt_clr = 0; cpu_req = 0; line_ld = 0; half_sel = 0;
    m_cnt = 8'd2; m_base = 9'h000;

    cyc(); cyc();
    chk("R2 hold", vaddr, 18'h00004);

    cnt_clr = 1'b1; cyc(); cnt_clr = 1'b0; m_cnt = 0;
    chk("R3 clear", vaddr, 0);
    steps(159);
    chk("R4 count 159", vaddr, {m_base, 8'd159, 1'b0});
    chk("R6 before window", irq, 0);
    steps(1);
    chk("R6 lag at 160", irq, 0);
    cyc();
    chk("R6 high", irq, 1);
    steps(10);
    cnt_clr = 1'b1; cyc(); cnt_clr = 1'b0; m_cnt = 0;
    chk("R7 clear keeps irq", irq, 1);
    chk("R3 clear in window", vaddr, 0);
    steps(191);
    chk("R7 still high at 191", irq, 1);
    steps(1);
    chk("R7 lag at 192", irq, 1);
    cyc();
    chk("R7 low", irq, 0);
    steps(7);
    chk("R4 count 199", vaddr, {9'h000, 8'd199, 1'b0});
    step_en = 1'b1; cnt_clr = 1'b1; cyc(); cnt_clr = 1'b0; step_en = 1'b0; m_cnt = 0;
    chk("R3 priority", vaddr, 0);

    line_ld = 1'b1; line_din = 9'h0FF; cyc(); line_ld = 1'b0; m_base = 9'h0FF;
    steps(255);
    half_sel = 1'b1; #1;
    chk("R4 count 255", vaddr, {9'h0FF, 8'd255, 1'b1});
    half_sel = 1'b0;
    steps(1);
    chk("R2 wrap", vaddr, {9'h0FF, 9'h000});
    chk("R7 low after wrap", irq, 0);

    cpu_req = 1'b1; cpu_addr = 9'h1FF; cyc();
    chk("R8 cpu addr", vaddr, {9'h0FF, 9'h1FF});
    steps(3);
    cpu_req = 1'b0; cyc();
    chk("R9 counted in cpu mode", vaddr, {9'h0FF, 8'd3, 1'b0});
    chk("R8 oe back", vid_oe, 1);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule